// File: doc/BRIEF.md
# Receiver Gain Control Sequencer

This block produces the step-attenuation codes for the I and Q receive channels of a receiver front end. It offers three modes. In manual mode a 5-bit code from a control register drives both channels. In per-frame automatic gain control, attenuation is raised during the first preamble periods of every incoming frame. Both channels move together until neither channel reports over-range. In latched gain leveling, a one-time calibration runs when its enable bit rises, while no response is present. Each channel's attenuation rises on its own until its noise detector goes quiet. The result is then frozen until the enable bit drops.

Each channel code has two fields. Bits [4:2] are the amplifier attenuation in 3 dB steps, from 0 (full gain) to 7. Bits [1:0] are the digitizer hysteresis reduction in 5 dB steps, from 0 to 3. In both automatic modes the sequencer drives only the amplifier field. The hysteresis field is always taken from the low bits of the manual code. The amplifier step applied by the per-frame control and the per-channel leveling results are exposed as status, together with done flags.

Top module: `rx_gain_seq`

## Requirements
- R1: After reset every status level is 0 and every done flag is 0, and both gain outputs equal `man_code`.
- R2: With `agc_en` and `agl_en` both low, `gain_i` and `gain_q` both equal `man_code`, following it in the same cycle.
- R3: When `agc_en` is high, `frame_start` clears the shared amplifier step to 0 and arms the control. Each following armed `pre_tick` on which `ovr_i` or `ovr_q` is high raises the step by 1, seen on `agc_level` the cycle after the tick. The step is the same on both channels.
- R4: An armed `pre_tick` with both over-range flags low sets `agc_done` and leaves the step unchanged. Later ticks have no effect until the next `frame_start`, which also clears `agc_done`.
- R5: The per-frame step never exceeds min(AGC_WIN, 7), which is 6 by default. The increment that reaches this limit also sets `agc_done`.
- R6: A rising edge on `agl_en` clears both leveling levels and both leveling done flags. After that, each `pre_tick` raises a channel's level by 1 while that channel's noise flag (`nse_i` or `nse_q`) is high. Each channel steps on its own.
- R7: A channel's leveling done flag is set when a tick finds its noise flag low (level unchanged), or when the increment that reaches level 7 is made. From then on, while `agl_en` stays high, that level holds whatever the ticks and noise flags do.
- R8: With `agl_en` high, each gain output is {leveling level of that channel, `man_code[1:0]`}. Otherwise, with `agc_en` high, both outputs are {`agc_level`, `man_code[1:0]`}. Leveling has priority over the per-frame control.
- R9: A falling edge on `agl_en` clears both leveling done flags and keeps the leveling levels. The outputs return to the per-frame or manual source.
- R10: A `frame_start` or `pre_tick` while `agc_en` is low changes neither `agc_level` nor `agc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agc_en | input | 1 | Per-frame automatic gain control enable |
| agl_en | input | 1 | Latched gain leveling enable; rising edge starts calibration |
| man_code | input | 5 | Manual code: [4:2] amplifier steps, [1:0] hysteresis steps |
| frame_start | input | 1 | Strobe at the start of a received frame |
| pre_tick | input | 1 | One pulse per preamble period |
| ovr_i | input | 1 | I digitizer over-range flag |
| ovr_q | input | 1 | Q digitizer over-range flag |
| nse_i | input | 1 | I noise/interference detect flag |
| nse_q | input | 1 | Q noise/interference detect flag |
| gain_i | output | 5 | I channel gain code |
| gain_q | output | 5 | Q channel gain code |
| agc_level | output | 3 | Shared amplifier step from per-frame control |
| agc_done | output | 1 | Per-frame control finished for this frame |
| agl_level_i | output | 3 | Leveling result for I |
| agl_level_q | output | 3 | Leveling result for Q |
| agl_done_i | output | 1 | Leveling finished for I |
| agl_done_q | output | 1 | Leveling finished for Q |

## Verification
The bench uses the default parameters: a 3-bit amplifier field, a 2-bit hysteresis field and a preamble window of 6 ticks. Because the window of 6 is below the amplifier ceiling of 7, the per-frame window limit (R5) and the leveling floor of 7 (R7) are two different stopping points. A run with the over-range flag held can therefore show the first, and a run with a noise flag held can show the second. The randomized phase toggles both enables at random, so it also reaches rising and falling edges of the leveling enable while a frame is being processed.

// File: rtl/rx_gain_seq.sv
module rx_gain_seq #(
  parameter int AMP_W   = 3,
  parameter int HYS_W   = 2,
  parameter int AGC_WIN = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   agc_en,
  input  logic                   agl_en,
  input  logic [AMP_W+HYS_W-1:0] man_code,
  input  logic                   frame_start,
  input  logic                   pre_tick,
  input  logic                   ovr_i,
  input  logic                   ovr_q,
  input  logic                   nse_i,
  input  logic                   nse_q,
  output logic [AMP_W+HYS_W-1:0] gain_i,
  output logic [AMP_W+HYS_W-1:0] gain_q,
  output logic [AMP_W-1:0]       agc_level,
  output logic                   agc_done,
  output logic [AMP_W-1:0]       agl_level_i,
  output logic [AMP_W-1:0]       agl_level_q,
  output logic                   agl_done_i,
  output logic                   agl_done_q
);
  localparam int AMP_TOP = (1 << AMP_W) - 1;
  localparam int LIM_I   = (AGC_WIN < AMP_TOP) ? AGC_WIN : AMP_TOP;
  localparam logic [AMP_W-1:0] AMP_MAX = AMP_TOP[AMP_W-1:0];
  localparam logic [AMP_W-1:0] LIM     = LIM_I[AMP_W-1:0];

  logic [AMP_W-1:0] agc_att;
  logic             agc_act;
  logic             agc_fin;
  logic             agl_en_q;
  logic             agl_rise;
  logic             agl_fall;
  logic [AMP_W-1:0] agl_att  [2];
  logic [1:0]       agl_busy;
  logic [1:0]       agl_fin;
  logic [1:0]       nse;
  logic             any_ovr;

  assign any_ovr  = ovr_i | ovr_q;
  assign nse      = {nse_q, nse_i};
  assign agl_rise = agl_en & ~agl_en_q;
  assign agl_fall = ~agl_en & agl_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agc_att <= '0;
      agc_act <= 1'b0;
      agc_fin <= 1'b0;
    end else if (agc_en && frame_start) begin
      agc_att <= '0;
      agc_act <= 1'b1;
      agc_fin <= 1'b0;
    end else if (agc_en && agc_act && pre_tick) begin
      if (any_ovr && agc_att != LIM) begin
        agc_att <= agc_att + 1'b1;
        if (agc_att == LIM - 1'b1) begin
          agc_act <= 1'b0;
          agc_fin <= 1'b1;
        end
      end else begin
        agc_act <= 1'b0;
        agc_fin <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) agl_en_q <= 1'b0;
    else        agl_en_q <= agl_en;
  end

  for (genvar c = 0; c < 2; c++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        agl_att[c]  <= '0;
        agl_busy[c] <= 1'b0;
        agl_fin[c]  <= 1'b0;
      end else if (agl_rise) begin
        agl_att[c]  <= '0;
        agl_busy[c] <= 1'b1;
        agl_fin[c]  <= 1'b0;
      end else if (agl_fall) begin
        agl_busy[c] <= 1'b0;
        agl_fin[c]  <= 1'b0;
      end else if (agl_busy[c] && pre_tick) begin
        if (nse[c] && agl_att[c] != AMP_MAX) begin
          agl_att[c] <= agl_att[c] + 1'b1;
          if (agl_att[c] == AMP_MAX - 1'b1) begin
            agl_busy[c] <= 1'b0;
            agl_fin[c]  <= 1'b1;
          end
        end else begin
          agl_busy[c] <= 1'b0;
          agl_fin[c]  <= 1'b1;
        end
      end
    end
  end

  wire [HYS_W-1:0] hys = man_code[HYS_W-1:0];

  assign gain_i = agl_en ? {agl_att[0], hys} : agc_en ? {agc_att, hys} : man_code;
  assign gain_q = agl_en ? {agl_att[1], hys} : agc_en ? {agc_att, hys} : man_code;

  assign agc_level   = agc_att;
  assign agc_done    = agc_fin;
  assign agl_level_i = agl_att[0];
  assign agl_level_q = agl_att[1];
  assign agl_done_i  = agl_fin[0];
  assign agl_done_q  = agl_fin[1];

  // R3
  agc_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (agc_att == $past(agc_att) || agc_att == $past(agc_att) + 1'b1));

  // R4
  agc_hold_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_fin && !frame_start) |=> $stable(agc_att));

  // R5
  agc_window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agc_att <= LIM);

  // R7
  agl_freeze_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agl_fin[0] && agl_en) |=> $stable(agl_att[0]));

  // R7
  agl_freeze_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agl_fin[1] && agl_en) |=> $stable(agl_att[1]));

  // R10
  agc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_en |=> ($stable(agc_att) && $stable(agc_fin)));

  // R8
  agc_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_en && !agl_en) |-> gain_i == gain_q);
endmodule

// File: tb/sim_rx_gain_seq.sv
`timescale 1ns/1ps
module sim_rx_gain_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic agc_en = 0, agl_en = 0, frame_start = 0, pre_tick = 0;
  logic ovr_i = 0, ovr_q = 0, nse_i = 0, nse_q = 0;
  logic [4:0] man_code = 5'b10110;
  logic [4:0] gain_i, gain_q;
  logic [2:0] agc_level, agl_level_i, agl_level_q;
  logic agc_done, agl_done_i, agl_done_q;

  always #2.5 clk = ~clk;

  rx_gain_seq u0 (.clk(clk), .rst_n(rst_n), .agc_en(agc_en), .agl_en(agl_en),
    .man_code(man_code), .frame_start(frame_start), .pre_tick(pre_tick),
    .ovr_i(ovr_i), .ovr_q(ovr_q), .nse_i(nse_i), .nse_q(nse_q),
    .gain_i(gain_i), .gain_q(gain_q), .agc_level(agc_level), .agc_done(agc_done),
    .agl_level_i(agl_level_i), .agl_level_q(agl_level_q),
    .agl_done_i(agl_done_i), .agl_done_q(agl_done_q));

  int tests = 0, fails = 0;
  bit ended = 0;
  localparam int LIM = 6;
  int m_att = 0, m_act = 0, m_fin = 0, m_enq = 0;
  int m_lv[2] = '{0, 0};
  int m_busy[2] = '{0, 0};
  int m_ld[2] = '{0, 0};

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_gain(int c);
    if (agl_en) return m_lv[c] * 4 + man_code[1:0];
    if (agc_en) return m_att * 4 + man_code[1:0];
    return man_code;
  endfunction

  task automatic model_step();
    int ns[2];
    ns[0] = nse_i; ns[1] = nse_q;
    if (agc_en && frame_start) begin
      m_att = 0; m_act = 1; m_fin = 0;
    end else if (agc_en && m_act && pre_tick) begin
      if ((ovr_i || ovr_q) && m_att < LIM) begin
        m_att++;
        if (m_att == LIM) begin m_act = 0; m_fin = 1; end
      end else begin m_act = 0; m_fin = 1; end
    end
    for (int c = 0; c < 2; c++) begin
      if (agl_en && !m_enq) begin
        m_lv[c] = 0; m_busy[c] = 1; m_ld[c] = 0;
      end else if (!agl_en && m_enq) begin
        m_busy[c] = 0; m_ld[c] = 0;
      end else if (m_busy[c] && pre_tick) begin
        if (ns[c] && m_lv[c] < 7) begin
          m_lv[c]++;
          if (m_lv[c] == 7) begin m_busy[c] = 0; m_ld[c] = 1; end
        end else begin m_busy[c] = 0; m_ld[c] = 1; end
      end
    end
    m_enq = agl_en;
  endtask

  task automatic cmp_all();
    chk("R8 gain_i", gain_i, exp_gain(0));
    chk("R8 gain_q", gain_q, exp_gain(1));
    chk("R3 agc_level", agc_level, m_att);
    chk("R4 agc_done", agc_done, m_fin);
    chk("R6 agl_level_i", agl_level_i, m_lv[0]);
    chk("R6 agl_level_q", agl_level_q, m_lv[1]);
    chk("R7 agl_done_i", agl_done_i, m_ld[0]);
    chk("R7 agl_done_q", agl_done_q, m_ld[1]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    cmp_all();
    frame_start = 0; pre_tick = 0;
  endtask

  task automatic tick(int oi, int oq, int ni, int nq);
    pre_tick = 1; ovr_i = oi[0]; ovr_q = oq[0]; nse_i = ni[0]; nse_q = nq[0];
    cyc();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      fails++; tests++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1c3a5;
    void'($urandom(seed));
    #12;
    chk("R1 gain_i", gain_i, 5'b10110);
    chk("R1 agc_level", agc_level, 0);
    chk("R1 agl_done_q", agl_done_q, 0);
    rst_n = 1;
    cyc();
    man_code = 5'b01001; #1;
    chk("R2 gain_i", gain_i, 5'b01001);
    chk("R2 gain_q", gain_q, 5'b01001);

    agc_en = 1; frame_start = 1; cyc();
    repeat (3) tick(1, 0, 0, 0);
    chk("R3 agc_level", agc_level, 3);
    chk("R3 gain_q", gain_q, 3 * 4 + 1);
    tick(0, 0, 0, 0);
    chk("R4 agc_done", agc_done, 1);
    repeat (2) tick(1, 1, 0, 0);
    chk("R4 agc_level", agc_level, 3);

    frame_start = 1; cyc();
    chk("R4 agc_done", agc_done, 0);
    repeat (8) tick(0, 1, 0, 0);
    chk("R5 agc_level", agc_level, 6);
    chk("R5 agc_done", agc_done, 1);

    agc_en = 0; frame_start = 1; cyc();
    tick(1, 1, 0, 0);
    chk("R10 agc_level", agc_level, 6);
    chk("R10 agc_done", agc_done, 1);
    chk("R2 gain_i", gain_i, 5'b01001);

    agc_en = 1; frame_start = 1; cyc();
    agl_en = 1; cyc();
    chk("R6 agl_level_i", agl_level_i, 0);
    tick(0, 0, 1, 1);
    tick(0, 0, 1, 1);
    repeat (7) tick(0, 0, 0, 1);
    chk("R6 agl_level_i", agl_level_i, 2);
    chk("R7 agl_level_q", agl_level_q, 7);
    chk("R7 agl_done_i", agl_done_i, 1);
    chk("R7 agl_done_q", agl_done_q, 1);
    repeat (3) tick(0, 0, 1, 1);
    chk("R7 agl_level_i", agl_level_i, 2);
    chk("R8 gain_i", gain_i, 2 * 4 + 1);
    chk("R8 gain_q", gain_q, 7 * 4 + 1);

    agl_en = 0; cyc();
    chk("R9 agl_done_i", agl_done_i, 0);
    chk("R9 agl_level_q", agl_level_q, 7);
    chk("R9 gain_i", gain_i, 0 * 4 + 1);

    for (int n = 0; n < 3000; n++) begin
      frame_start = ($urandom_range(15) == 0);
      pre_tick = ($urandom_range(2) == 0);
      ovr_i = $urandom_range(1); ovr_q = $urandom_range(1);
      nse_i = ($urandom_range(3) != 0); nse_q = ($urandom_range(3) != 0);
      if ($urandom_range(39) == 0) agc_en = ~agc_en;
      if ($urandom_range(59) == 0) agl_en = ~agl_en;
      if ($urandom_range(99) == 0) man_code = 5'($urandom);
      cyc();
    end

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule